// File: doc/BRIEF.md
# Unsigned Word Divide Execution Unit

This block is the fixed-point divide unit of an integer core. It accepts a 32-bit unsigned dividend and divisor on a start pulse, runs a shift-subtract loop that retires one quotient bit per clock, and returns the quotient with a one-cycle done pulse. The operands, the form bits and the incoming flag state are all captured on the accepting edge. While the unit is busy, further start pulses are ignored.

Two form bits select which status the unit produces. The overflow-enable bit lets it write the overflow flag and the sticky summary-overflow flag. The record bit lets it write a 4-bit condition field, whose sign bits come from reading the unsigned quotient as a signed two's-complement value. The caller supplies the current summary-overflow, overflow, carry and condition-field values. The unit returns the updated values, and any flag that the form does not write comes back exactly as it was supplied. A zero divisor is detected on the accepting edge. In that case the unit finishes early with a quotient of zero.

Top module: `udw_div_unit`

## Requirements
- R1: For a nonzero divisor, quot_o equals the unsigned integer quotient floor(dividend / divisor) of the operands captured at the accepting edge.
- R2: A start_i sampled high while busy_o is low is accepted. With a nonzero divisor, busy_o is high from the accepting edge until done_o rises, and done_o rises on the 33rd rising edge after the accepting edge.
- R3: With a zero divisor, done_o rises on the first rising edge after the accepting edge, and quot_o is all zeros.
- R4: done_o is high for exactly one cycle per accepted start, and busy_o is low whenever done_o is high.
- R5: A start_i pulse while busy_o is high has no effect: the result and the flags belong to the original operation, and there is exactly one done pulse.
- R6: With overflow-enable set, ov_o is 1 when the divisor is zero and 0 otherwise.
- R7: With overflow-enable set, so_o is the captured so_i ORed with the new overflow value. A set summary bit is therefore never cleared.
- R8: With overflow-enable clear, ov_o and so_o equal the captured ov_i and so_i.
- R9: With record set, cr_o bit 3 is LT (quotient bit 31 set), bit 2 is GT (quotient nonzero and bit 31 clear), bit 1 is EQ (quotient zero), and bit 0 is the updated summary-overflow value.
- R10: With record clear, cr_o equals the captured cr_i.
- R11: ca_o always equals the captured ca_i, for all four forms.
- R12: After reset, all outputs are zero. Results hold their values from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| dividend_i | input | 32 | Unsigned dividend |
| divisor_i | input | 32 | Unsigned divisor |
| ovf_en_i | input | 1 | Overflow-enable form bit |
| rec_i | input | 1 | Record form bit |
| so_i | input | 1 | Current summary-overflow flag |
| ov_i | input | 1 | Current overflow flag |
| ca_i | input | 1 | Current carry flag |
| cr_i | input | 4 | Current condition field |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 32 | Quotient |
| so_o | output | 1 | Updated summary-overflow flag |
| ov_o | output | 1 | Updated overflow flag |
| ca_o | output | 1 | Carry flag, passed through |
| cr_o | output | 4 | Updated condition field |

## Verification
Every result is due on the same edge that raises done_o. That edge is the 33rd rising edge after the accepting edge for a nonzero divisor, and the first for a zero divisor. The bench drives start_i on a falling edge and counts falling edges until it sees done_o. It checks that count against the expected latency and samples quotient and flags in that same half-cycle. On the falling edge after that, it confirms that done_o has dropped and that the results still hold their values.

// File: rtl/udw_pkg.sv
package udw_pkg;
  localparam int unsigned DW  = 32;
  localparam int unsigned CRW = 4;

  // Condition field bit positions, decoded by the branch unit
  localparam int unsigned CR_LT = 3;
  localparam int unsigned CR_GT = 2;
  localparam int unsigned CR_EQ = 1;
  localparam int unsigned CR_SO = 0;

  typedef struct packed {
    logic           ovf_en;
    logic           rec;
    logic           so;
    logic           ov;
    logic           ca;
    logic [CRW-1:0] cr;
    logic           dz;
  } udw_ctl_t;

  typedef struct packed {
    logic           so;
    logic           ov;
    logic           ca;
    logic [CRW-1:0] cr;
  } udw_flags_t;
endpackage

// File: rtl/udw_seq.sv
module udw_seq #(
  parameter int unsigned STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic dz_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic fin_o
);
  localparam int unsigned CW = $clog2(STEPS) + 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic          busy_q, busy_d;
  logic          fin_q, fin_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign load_o = start_i && !busy_q;
  assign step_o = busy_q && !fin_q;
  assign fin_o  = busy_q && fin_q;
  assign busy_o = busy_q;

  always_comb begin
    busy_d = busy_q;
    fin_d  = fin_q;
    cnt_d  = cnt_q;
    if (load_o) begin
      busy_d = 1'b1;
      fin_d  = dz_i;
      cnt_d  = '0;
    end else if (fin_o) begin
      busy_d = 1'b0;
      fin_d  = 1'b0;
    end else if (step_o) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) fin_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_d;
      cnt_q  <= cnt_d;
    end
  end

  // R2: the step counter never runs past the last quotient bit
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> cnt_q <= LAST);
  // R4: the finish phase lasts a single cycle
  a_r4_fin_once: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !busy_q);
endmodule

// File: rtl/udw_core.sv
module udw_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic [W:0]   rem_o,
  output logic [W-1:0] dvs_o
);
  logic [W:0]   rem_q, rem_d;
  logic [W-1:0] q_q, q_d;
  logic [W-1:0] dvs_q, dvs_d;
  logic [W:0]   shifted;
  logic [W:0]   diff;
  logic         fits;

  assign shifted = {rem_q[W-1:0], q_q[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign fits    = shifted >= {1'b0, dvs_q};

  always_comb begin
    rem_d = rem_q;
    q_d   = q_q;
    dvs_d = dvs_q;
    if (load_i) begin
      rem_d = '0;
      q_d   = dividend_i;
      dvs_d = divisor_i;
    end else if (step_i) begin
      rem_d = fits ? diff : shifted;
      q_d   = {q_q[W-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      q_q   <= '0;
      dvs_q <= '0;
    end else if (load_i || step_i) begin
      rem_q <= rem_d;
      q_q   <= q_d;
      dvs_q <= dvs_d;
    end
  end

  assign quot_o = q_q;
  assign rem_o  = rem_q;
  assign dvs_o  = dvs_q;

  // R1: the partial remainder stays below the divisor after every step
  a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && dvs_q != '0) |=> rem_q < {1'b0, dvs_q});
endmodule

// File: rtl/udw_flags.sv
module udw_flags
  import udw_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] quot_i,
  input  udw_ctl_t     ctl_i,
  output udw_flags_t   flags_o
);
  logic ov_new, so_new;
  logic lt, gt, eq;

  always_comb begin
    ov_new = ctl_i.ovf_en ? ctl_i.dz : ctl_i.ov;
    so_new = ctl_i.ovf_en ? (ctl_i.so | ctl_i.dz) : ctl_i.so;
    eq     = (quot_i == '0);
    lt     = quot_i[W-1];
    gt     = !lt && !eq;
    flags_o.ov = ov_new;
    flags_o.so = so_new;
    flags_o.ca = ctl_i.ca;
    flags_o.cr = ctl_i.cr;
    if (ctl_i.rec) begin
      flags_o.cr[CR_LT] = lt;
      flags_o.cr[CR_GT] = gt;
      flags_o.cr[CR_EQ] = eq;
      flags_o.cr[CR_SO] = so_new;
    end
  end
endmodule

// File: rtl/udw_div_unit.sv
module udw_div_unit
  import udw_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [DW-1:0]  dividend_i,
  input  logic [DW-1:0]  divisor_i,
  input  logic           ovf_en_i,
  input  logic           rec_i,
  input  logic           so_i,
  input  logic           ov_i,
  input  logic           ca_i,
  input  logic [CRW-1:0] cr_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [DW-1:0]  quot_o,
  output logic           so_o,
  output logic           ov_o,
  output logic           ca_o,
  output logic [CRW-1:0] cr_o
);
  logic          load, step, fin, dz_in;
  logic [DW-1:0] core_q, core_dvs, quot_fin;
  logic [DW:0]   core_rem;
  udw_ctl_t      ctl_q, ctl_d;
  udw_flags_t    flags_fin, flags_q;
  logic [DW-1:0] quot_q;
  logic          done_q;

  assign dz_in = (divisor_i == '0);

  udw_seq #(.STEPS(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dz_i(dz_in),
    .busy_o(busy_o), .load_o(load), .step_o(step), .fin_o(fin)
  );

  udw_core #(.W(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .quot_o(core_q), .rem_o(core_rem), .dvs_o(core_dvs)
  );

  assign quot_fin = ctl_q.dz ? '0 : core_q;

  udw_flags #(.W(DW)) u_flags (
    .quot_i(quot_fin), .ctl_i(ctl_q), .flags_o(flags_fin)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (load) begin
      ctl_d.ovf_en = ovf_en_i;
      ctl_d.rec    = rec_i;
      ctl_d.so     = so_i;
      ctl_d.ov     = ov_i;
      ctl_d.ca     = ca_i;
      ctl_d.cr     = cr_i;
      ctl_d.dz     = dz_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (load) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q  <= '0;
      flags_q <= '0;
    end else if (fin) begin
      quot_q  <= quot_fin;
      flags_q <= flags_fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= fin;
  end

  assign done_o = done_q;
  assign quot_o = quot_q;
  assign so_o   = flags_q.so;
  assign ov_o   = flags_q.ov;
  assign ca_o   = flags_q.ca;
  assign cr_o   = flags_q.cr;

  // R4: done is a single-cycle pulse and never overlaps busy
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R5: a start while busy leaves the captured operation untouched
  a_r5_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(ctl_q) && $stable(core_dvs)));
  // R1: final remainder is below the divisor
  a_r1_final_rem: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !ctl_q.dz) |-> core_rem < {1'b0, core_dvs});
  // R7: a set summary flag survives any overflow-enabled form
  a_r7_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && ctl_q.so) |=> so_o);
  // R10: record clear returns the captured condition field
  a_r10_cr_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !ctl_q.rec) |=> cr_o == $past(ctl_q.cr));
  // R12: results hold between done pulses
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(quot_o));
endmodule

// File: tb/udw_div_unit_test.sv
module udw_div_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] dividend_i, divisor_i;
  logic        ovf_en_i, rec_i, so_i, ov_i, ca_i;
  logic [3:0]  cr_i;
  logic        busy_o, done_o, so_o, ov_o, ca_o;
  logic [31:0] quot_o;
  logic [3:0]  cr_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  udw_div_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .ovf_en_i(ovf_en_i), .rec_i(rec_i), .so_i(so_i), .ov_i(ov_i),
    .ca_i(ca_i), .cr_i(cr_i), .busy_o(busy_o), .done_o(done_o),
    .quot_o(quot_o), .so_o(so_o), .ov_o(ov_o), .ca_o(ca_o), .cr_o(cr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cr(input logic [31:0] q, input logic so_n,
                                        input logic rc, input logic [3:0] cr_old);
    if (!rc) return cr_old;
    return {q[31], (q != 0) && !q[31], q == 0, so_n};
  endfunction

  // Runs one operation; inj injects a start while busy (R5)
  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic oe, input logic rc, input logic so,
                        input logic ov, input logic ca, input logic [3:0] cr,
                        input bit inj);
    int k;
    logic [31:0] eq;
    logic ov_n, so_n;
    dividend_i = a; divisor_i = b; ovf_en_i = oe; rec_i = rc;
    so_i = so; ov_i = ov; ca_i = ca; cr_i = cr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = 1;
    check("R2 busy after accept", {31'd0, busy_o}, 32'd1);
    while (!done_o && k < 60) begin
      if (inj && k == 5) begin
        dividend_i = ~a; divisor_i = 32'd3; ovf_en_i = ~oe; rec_i = ~rc;
        so_i = ~so; ov_i = ~ov; ca_i = ~ca; cr_i = ~cr; start_i = 1'b1;
      end else start_i = 1'b0;
      @(negedge clk);
      k++;
      if (!done_o && k < 34 && b != 0)
        check("R2 busy held", {31'd0, busy_o}, 32'd1);
    end
    start_i = 1'b0;
    check(b == 0 ? "R3 latency" : "R2 latency", k, b == 0 ? 32'd2 : 32'd34);
    check("R4 busy low at done", {31'd0, busy_o}, 32'd0);
    eq   = (b == 0) ? 32'd0 : a / b;
    ov_n = oe ? (b == 0) : ov;
    so_n = oe ? (so | (b == 0)) : so;
    check(b == 0 ? "R3 quotient zero" : (inj ? "R5 quotient" : "R1 quotient"), quot_o, eq);
    check(oe ? "R6 ov" : "R8 ov", {31'd0, ov_o}, {31'd0, ov_n});
    check(oe ? "R7 so" : "R8 so", {31'd0, so_o}, {31'd0, so_n});
    check("R11 ca", {31'd0, ca_o}, {31'd0, ca});
    check(rc ? "R9 cr" : "R10 cr", {28'd0, cr_o}, {28'd0, exp_cr(eq, so_n, rc, cr)});
    @(negedge clk);
    check("R4 done drops", {31'd0, done_o}, 32'd0);
    check("R12 quotient holds", quot_o, eq);
    if (inj) check("R5 no second run", {31'd0, busy_o}, 32'd0);
  endtask

  initial begin
    start_i = 0; dividend_i = 0; divisor_i = 0; ovf_en_i = 0; rec_i = 0;
    so_i = 0; ov_i = 0; ca_i = 0; cr_i = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 reset done", {31'd0, done_o}, 32'd0);
    check("R12 reset busy", {31'd0, busy_o}, 32'd0);
    check("R12 reset quot", quot_o, 32'd0);
    check("R12 reset flags", {25'd0, so_o, ov_o, ca_o, cr_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases over the four forms
    for (int f = 0; f < 4; f++) begin
      run_op(32'h0000_0000, 32'd2, f[1], f[0], 1'b0, 1'b1, 1'b1, 4'b1010, 0);
      run_op(32'd2, 32'd2, f[1], f[0], 1'b0, 1'b0, 1'b0, 4'b0101, 0);
      run_op(32'h8000_0000, 32'd2, f[1], f[0], 1'b0, 1'b1, 1'b0, 4'b0000, 0);
      run_op(32'h0000_0001, 32'd0, f[1], f[0], 1'b0, 1'b0, 1'b1, 4'b0110, 0);
      run_op(32'hFFFF_FFFF, 32'd1, f[1], f[0], 1'b1, 1'b0, 1'b0, 4'b1111, 0);
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, f[1], f[0], 1'b1, 1'b1, 1'b1, 4'b0011, 0);
      run_op(32'd5, 32'hFFFF_FFFF, f[1], f[0], 1'b0, 1'b1, 1'b0, 4'b1001, 0);
      run_op(32'hF000_0000, 32'd0, f[1], f[0], 1'b1, 1'b1, 1'b0, 4'b1100, 0);
      run_op(32'd1000, 32'd7, f[1], f[0], 1'b0, 1'b0, 1'b1, 4'b0001, 1);
    end

    // Constrained random: mixes powers of two and edge values
    void'($urandom(32'd20240611));
    for (int i = 0; i < 80; i++) begin
      logic [31:0] a, b;
      int sel;
      a = $urandom;
      sel = $urandom_range(0, 5);
      case (sel)
        0: b = 32'd1 << $urandom_range(0, 31);
        1: b = 32'd0;
        2: b = 32'hFFFF_FFFF;
        3: b = $urandom_range(1, 255);
        default: b = $urandom;
      endcase
      if ($urandom_range(0, 7) == 0) a = 32'hFFFF_FFFF;
      run_op(a, b, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 4'($urandom), (i % 10) == 3);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule